// File: doc/BRIEF.md
# I2C Slave Write Receiver with Two-Byte Receive Queue

This block is the receive half of an I2C target device. It watches the SCL and SDA lines, finds START and STOP conditions, and checks the first byte of each transfer against its own 7-bit device address. The block accepts the transfer only when that byte also carries the write direction. It then shifts in the data bytes that follow and pulls SDA low in the acknowledge slot of each byte it accepts. Both bus inputs arrive already synchronized to `clk`, and the SDA output is an open-drain pull-down enable.

Accepted bytes go into a receive queue that holds two entries. A one-cycle receive interrupt follows each stored byte. When a third byte arrives before software has drained the queue, the block answers that byte with NACK, discards it and raises a sticky overflow flag. A small register port lets software pop the queue, read and clear status, and flush the queue.

Top module: `i2c_rx_slave`

## Requirements
- R1: After reset, SDA is released (`sda_low_o`=0), `rx_irq_o` is 0, the status register reads 0x00 and a data register read returns 0x00.
- R2: The first byte after a START holds the 7-bit address in bits 7..1, sent MSB first, and the direction in bit 0. The block drives ACK only when the address equals `DEV_ADDR` and the direction is 0 (write).
- R3: On an address mismatch or a read direction, the block keeps SDA released for the rest of the transfer, including the acknowledge slots of any later bytes. It stores nothing until the next START.
- R4: Data bytes are received MSB first. Each accepted byte is acknowledged and appended to the queue. A read of the data register (`reg_sel_i`=0) returns the oldest byte and removes it.
- R5: `rx_irq_o` gives a one-cycle pulse for every byte written into the queue, after the ninth SCL clock of that byte. It does not pulse for address bytes or for rejected bytes.
- R6: The queue holds two bytes. A byte that arrives while the queue is full gets a NACK and is discarded, and the queued bytes are kept.
- R7: Status register (`reg_sel_i`=1) bit 4 sets on a queue overflow and stays set until software writes a 1 to bit 4 of the status register. A write with bit 4 at 0 leaves it set.
- R8: Status bit 3 sets when a byte is stored. Only a data register read clears it, and only when no byte remains in the queue after that read. A flush leaves bit 3 unchanged.
- R9: Writing a 1 to bit 0 of the control register (`reg_sel_i`=2) empties both queue entries in one clock. The next accepted byte then becomes the head of the queue.
- R10: A data register read while the queue is empty returns 0x00 and leaves the queue contents unchanged.
- R11: A repeated START in the middle of a transfer restarts address matching. A STOP returns the receiver to idle and resets the bit counter, so a byte cut short by a STOP is dropped and the next transfer starts clean.
- R12: SDA is sampled on SCL rising edges. The block changes its ACK drive only while SCL is low: it drives after the falling edge of the eighth SCL and releases after the falling edge of the ninth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA bus level |
| sda_low_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| reg_rd_i | input | 1 | Register read strobe, one cycle |
| reg_wr_i | input | 1 | Register write strobe, one cycle |
| reg_sel_i | input | 2 | Register select: 0 data, 1 status, 2 control |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the selected register |
| rx_irq_o | output | 1 | One-cycle receive interrupt per stored byte |

## Verification
The bench sends a byte that equals the device's own address pattern right after a mismatched address. A receiver that did not truly ignore the rest of a rejected transfer would acknowledge that byte. The bench fills the queue past its depth and checks three things: the third byte gets a NACK, the first two bytes come back intact, and the overflow flag survives a write with bit 4 at 0. A design that overwrote entries or cleared the flag on any write would show up there. It also flushes the queue with the receive flag set and checks that the flag holds and that the following byte lands at the head. Finally it cuts a byte short with a STOP and issues a repeated START both to and from a matching address, which exposes a bit counter or address state that is not restarted.

// File: rtl/i2crx_pkg.sv
package i2crx_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    localparam int STAT_AVAIL_BIT = 3;
    localparam int STAT_OVF_BIT   = 4;
    localparam int CTRL_FLUSH_BIT = 0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_SKIP = 2'd3
    } rx_state_e;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CTRL = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    function automatic logic addr_hit(logic [BYTE_W-1:0] b, logic [ADDR_W-1:0] a);
        return (b[BYTE_W-1:1] == a) && !b[0];
    endfunction

    function automatic logic [BYTE_W-1:0] status_word(logic avail, logic ovf);
        logic [BYTE_W-1:0] w;
        w = '0;
        w[STAT_AVAIL_BIT] = avail;
        w[STAT_OVF_BIT]   = ovf;
        return w;
    endfunction

endpackage

// File: rtl/i2crx_line_mon.sv
module i2crx_line_mon
    import i2crx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        evt_o.start    = scl_i & scl_q & sda_q & ~sda_i;
        evt_o.stop     = scl_i & scl_q & ~sda_q & sda_i;
        evt_o.scl_rise = scl_i & ~scl_q;
        evt_o.scl_fall = ~scl_i & scl_q;
        evt_o.sda      = sda_i;
    end

endmodule

// File: rtl/i2crx_byte_engine.sv
module i2crx_byte_engine
    import i2crx_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h2C
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt_i,
    input  logic              q_full_i,
    output logic              sda_low_o,
    output logic              push_o,
    output logic [BYTE_W-1:0] push_data_o,
    output logic              ovf_o
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    rx_state_e         state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              ack_phase;
    logic              accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            bit_cnt     <= '0;
            shreg       <= '0;
            ack_phase   <= 1'b0;
            accept      <= 1'b0;
            sda_low_o   <= 1'b0;
            push_o      <= 1'b0;
            push_data_o <= '0;
            ovf_o       <= 1'b0;
        end else begin
            push_o <= 1'b0;
            ovf_o  <= 1'b0;
            if (evt_i.start) begin
                state     <= ST_ADDR;
                bit_cnt   <= '0;
                ack_phase <= 1'b0;
                accept    <= 1'b0;
                sda_low_o <= 1'b0;
            end else if (evt_i.stop) begin
                state     <= ST_IDLE;
                bit_cnt   <= '0;
                ack_phase <= 1'b0;
                accept    <= 1'b0;
                sda_low_o <= 1'b0;
            end else if (state != ST_IDLE) begin
                if (evt_i.scl_rise && !ack_phase && bit_cnt < LAST_BIT) begin
                    shreg   <= {shreg[BYTE_W-2:0], evt_i.sda};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                if (evt_i.scl_fall) begin
                    if (!ack_phase && bit_cnt == LAST_BIT) begin
                        ack_phase <= 1'b1;
                        case (state)
                            ST_ADDR: begin
                                if (addr_hit(shreg, DEV_ADDR)) sda_low_o <= 1'b1;
                                else                           state     <= ST_SKIP;
                            end
                            ST_DATA: begin
                                if (!q_full_i) begin
                                    sda_low_o <= 1'b1;
                                    accept    <= 1'b1;
                                end else begin
                                    ovf_o <= 1'b1;
                                end
                            end
                            default: ;
                        endcase
                    end else if (ack_phase) begin
                        ack_phase <= 1'b0;
                        bit_cnt   <= '0;
                        sda_low_o <= 1'b0;
                        accept    <= 1'b0;
                        if (state == ST_ADDR) state <= ST_DATA;
                        if (state == ST_DATA && accept) begin
                            push_o      <= 1'b1;
                            push_data_o <= shreg;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/i2crx_fifo.sv
module i2crx_fifo #(
    parameter int DEPTH = 2,
    parameter int W     = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push_i,
    input  logic [W-1:0]                 push_data_i,
    input  logic                         pop_i,
    input  logic                         flush_i,
    output logic [W-1:0]                 head_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o,
    output logic                         full_o,
    output logic                         empty_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic             do_push;
    logic             do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    assign full_o  = (cnt == CNT_MAX);
    assign empty_o = (cnt == '0);
    assign count_o = cnt;
    assign head_o  = mem[rd_ptr];
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: ;
            endcase
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem[i] <= '0;
                end else if (do_push && !flush_i && wr_ptr == PTR_W'(i)) begin
                    mem[i] <= push_data_i;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/i2c_rx_slave.sv
module i2c_rx_slave
    import i2crx_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR   = 7'h2C,
    parameter int         FIFO_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_low_o,
    input  logic       reg_rd_i,
    input  logic       reg_wr_i,
    input  logic [1:0] reg_sel_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    output logic       rx_irq_o
);

    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    bus_evt_t          evt;
    logic              eng_push;
    logic [BYTE_W-1:0] eng_data;
    logic              eng_ovf;
    logic [BYTE_W-1:0] q_head;
    logic [CNT_W-1:0]  q_count;
    logic              q_full;
    logic              q_empty;
    logic              data_rd;
    logic              q_pop;
    logic              q_flush;
    logic              ovf_clr;
    logic              rx_avail;
    logic              ovf_flag;

    i2crx_line_mon u_mon (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt)
    );

    i2crx_byte_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
        .clk         (clk),
        .rst         (rst),
        .evt_i       (evt),
        .q_full_i    (q_full),
        .sda_low_o   (sda_low_o),
        .push_o      (eng_push),
        .push_data_o (eng_data),
        .ovf_o       (eng_ovf)
    );

    i2crx_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
        .clk         (clk),
        .rst         (rst),
        .push_i      (eng_push),
        .push_data_i (eng_data),
        .pop_i       (q_pop),
        .flush_i     (q_flush),
        .head_o      (q_head),
        .count_o     (q_count),
        .full_o      (q_full),
        .empty_o     (q_empty)
    );

    assign data_rd = reg_rd_i && (reg_sel_i == SEL_DATA);
    assign q_pop   = data_rd && !q_empty;
    assign q_flush = reg_wr_i && (reg_sel_i == SEL_CTRL) && reg_wdata_i[CTRL_FLUSH_BIT];
    assign ovf_clr = reg_wr_i && (reg_sel_i == SEL_STAT) && reg_wdata_i[STAT_OVF_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_avail <= 1'b0;
            ovf_flag <= 1'b0;
            rx_irq_o <= 1'b0;
        end else begin
            rx_irq_o <= eng_push;
            if (eng_push)                                 rx_avail <= 1'b1;
            else if (data_rd && q_count <= CNT_W'(1))     rx_avail <= 1'b0;
            if (eng_ovf)      ovf_flag <= 1'b1;
            else if (ovf_clr) ovf_flag <= 1'b0;
        end
    end

    always_comb begin
        case (reg_sel_i)
            SEL_DATA: reg_rdata_o = q_empty ? '0 : q_head;
            SEL_STAT: reg_rdata_o = status_word(rx_avail, ovf_flag);
            default:  reg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/i2crx_checker.sv
module i2crx_checker #(
    parameter int DEPTH = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       scl_i,
    input logic                       sda_low_o,
    input logic                       rx_irq_o,
    input logic                       push,
    input logic [$clog2(DEPTH+1)-1:0] fifo_cnt,
    input logic                       rx_avail,
    input logic                       ovf_flag,
    input logic                       reg_rd_i,
    input logic                       reg_wr_i,
    input logic [1:0]                 reg_sel_i,
    input logic [7:0]                 reg_wdata_i,
    input logic [7:0]                 reg_rdata_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    // R1
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sda_low_o && !rx_irq_o));

    // R12
    a_r12_ack_rises_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_low_o) |-> !scl_i);

    // R5
    a_r5_irq_single_cycle: assert property (@(posedge clk) disable iff (rst)
        rx_irq_o |=> !rx_irq_o);

    // R6
    a_r6_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
        push |-> (fifo_cnt < CNT_W'(DEPTH)));

    // R8
    a_r8_flag_with_data: assert property (@(posedge clk) disable iff (rst)
        (fifo_cnt != '0) |-> rx_avail);

    // R7
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !(reg_wr_i && reg_sel_i == 2'd1 && reg_wdata_i[4])) |=> ovf_flag);

    // R10
    a_r10_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_i && reg_sel_i == 2'd0 && fifo_cnt == '0) |-> (reg_rdata_o == 8'h00));

endmodule

bind i2c_rx_slave i2crx_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .scl_i       (scl_i),
    .sda_low_o   (sda_low_o),
    .rx_irq_o    (rx_irq_o),
    .push        (eng_push),
    .fifo_cnt    (q_count),
    .rx_avail    (rx_avail),
    .ovf_flag    (ovf_flag),
    .reg_rd_i    (reg_rd_i),
    .reg_wr_i    (reg_wr_i),
    .reg_sel_i   (reg_sel_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o)
);

// File: tb/tb_i2c_rx_slave.sv
module tb_i2c_rx_slave;

    localparam int Q = 4;
    localparam logic [6:0] MY_ADDR = 7'h2C;
    localparam int NVEC = 8;
    // {addr7, rw, data8, expect_ack}
    localparam logic [16:0] VEC [NVEC] = '{
        {7'h2C, 1'b0, 8'hA5, 1'b1},
        {7'h2C, 1'b0, 8'h00, 1'b1},
        {7'h2C, 1'b0, 8'hFF, 1'b1},
        {7'h2D, 1'b0, 8'h11, 1'b0},
        {7'h2C, 1'b1, 8'h22, 1'b0},
        {7'h6C, 1'b0, 8'h58, 1'b0},
        {7'h2C, 1'b0, 8'h5A, 1'b1},
        {7'h0C, 1'b0, 8'h58, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_low;
    logic       bus_sda;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       rx_irq;

    int n_chk = 0;
    int n_bad = 0;
    int irq_cnt = 0;

    always #4 clk = ~clk;

    assign bus_sda = m_sda & ~sda_low;

    i2c_rx_slave #(.DEV_ADDR(MY_ADDR), .FIFO_DEPTH(2)) dut (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (m_scl),
        .sda_i       (bus_sda),
        .sda_low_o   (sda_low),
        .reg_rd_i    (reg_rd),
        .reg_wr_i    (reg_wr),
        .reg_sel_i   (reg_sel),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .rx_irq_o    (rx_irq)
    );

    always @(posedge clk) if (!rst && rx_irq) irq_cnt <= irq_cnt + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        if (!m_scl) begin
            m_sda = 1'b1; qw();
            m_scl = 1'b1; qw();
        end
        m_sda = 1'b0; qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qw();
        m_scl = 1'b1; qw();
        m_sda = 1'b1; qw();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; qw();
        m_scl = 1'b1; qw(); qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; qw();
        m_scl = 1'b1; qw();
        ack = ~bus_sda;
        qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic cpu_read(input logic [1:0] sel, output logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic cpu_write(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic       ack;
        int         irq0;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk("R1 sda released", 32'(sda_low), 0);
        chk("R1 irq low", 32'(rx_irq), 0);
        cpu_read(2'd1, d); chk("R1 status", 32'(d), 0);
        cpu_read(2'd0, d); chk("R1 data", 32'(d), 0);

        // Table walk: R2 R3 R4 R5
        for (int v = 0; v < NVEC; v++) begin
            logic [6:0] a;
            logic       rw;
            logic [7:0] db;
            logic       ea;
            {a, rw, db, ea} = VEC[v];
            irq0 = irq_cnt;
            bus_start();
            send_byte({a, rw}, ack);
            chk("R2 address ack", 32'(ack), 32'(ea));
            send_byte(db, ack);
            chk("R3/R4 data ack", 32'(ack), 32'(ea));
            bus_stop();
            chk("R5 irq count", 32'(irq_cnt - irq0), 32'(ea));
            cpu_read(2'd0, d);
            chk("R4 data value", 32'(d), ea ? 32'(db) : 0);
            cpu_read(2'd1, d);
            chk("R8 status after read", 32'(d), 0);
        end

        // R6 R7 R8: overflow on third byte
        irq0 = irq_cnt;
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        send_byte(8'h81, ack); chk("R6 byte1 ack", 32'(ack), 1);
        send_byte(8'h42, ack); chk("R6 byte2 ack", 32'(ack), 1);
        send_byte(8'h24, ack); chk("R6 byte3 nack", 32'(ack), 0);
        bus_stop();
        chk("R5 irq only stored bytes", 32'(irq_cnt - irq0), 2);
        cpu_read(2'd1, d); chk("R7 overflow set", 32'(d), 32'h18);
        cpu_read(2'd0, d); chk("R6 first kept", 32'(d), 32'h81);
        cpu_read(2'd1, d); chk("R8 flag with byte left", 32'(d), 32'h18);
        cpu_read(2'd0, d); chk("R6 second kept", 32'(d), 32'h42);
        cpu_read(2'd1, d); chk("R8 flag cleared by read", 32'(d), 32'h10);
        cpu_read(2'd0, d); chk("R6 third discarded", 32'(d), 0);
        cpu_write(2'd1, 8'h08);
        cpu_read(2'd1, d); chk("R7 sticky on bit4=0", 32'(d), 32'h10);
        cpu_write(2'd1, 8'h10);
        cpu_read(2'd1, d); chk("R7 w1c clears", 32'(d), 0);

        // R9 R8 flush
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        send_byte(8'h9C, ack);
        send_byte(8'h6E, ack);
        bus_stop();
        cpu_write(2'd2, 8'h01);
        cpu_read(2'd1, d); chk("R8 flush keeps flag", 32'(d), 32'h08);
        cpu_read(2'd0, d); chk("R9 flushed empty", 32'(d), 0);
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        send_byte(8'h55, ack);
        bus_stop();
        cpu_read(2'd0, d); chk("R9 new head after flush", 32'(d), 32'h55);

        // R10 empty reads change nothing
        cpu_read(2'd0, d); chk("R10 empty read", 32'(d), 0);
        cpu_read(2'd0, d);
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        send_byte(8'h12, ack);
        send_byte(8'h34, ack); chk("R10 room after empty reads", 32'(ack), 1);
        bus_stop();
        cpu_read(2'd0, d); chk("R10 order kept", 32'(d), 32'h12);
        cpu_read(2'd0, d); chk("R10 order kept 2", 32'(d), 32'h34);

        // R11 repeated START
        bus_start();
        send_byte({7'h11, 1'b0}, ack);
        send_byte(8'h58, ack); chk("R3 ignored byte nack", 32'(ack), 0);
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack); chk("R11 restart match", 32'(ack), 1);
        send_byte(8'h77, ack);
        bus_start();
        send_byte({MY_ADDR, 1'b1}, ack); chk("R11 restart read nack", 32'(ack), 0);
        bus_stop();
        cpu_read(2'd0, d); chk("R11 byte before restart", 32'(d), 32'h77);
        cpu_read(2'd0, d); chk("R11 nothing more", 32'(d), 0);

        // R11 STOP mid-byte resets bit count
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_stop();
        cpu_read(2'd0, d); chk("R11 partial dropped", 32'(d), 0);
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack); chk("R11 clean after stop", 32'(ack), 1);
        send_byte(8'h3C, ack);
        bus_stop();
        cpu_read(2'd0, d); chk("R11 next byte aligned", 32'(d), 32'h3C);

        // R12 ack released after ninth clock
        chk("R12 sda released idle", 32'(sda_low), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule